// File: doc/BRIEF.md
# Opcode-Selected Arithmetic-Logic Unit with Condition Flags

This block takes two 16-bit operands and a 4-bit operation code. It produces one result word together with three condition flags: negative, zero and overflow. It also produces a strobe that tells the surrounding datapath whether the flag register held outside this block should take the new flag values. The operations are:

- constants: all zeros and all ones;
- bitwise NOT, AND, OR and XOR;
- pass-through of the second operand;
- addition, subtraction and two's-complement negation;
- a compare that forms the second operand minus the first;
- logical shifts in both directions.

The shift count is taken from the low four bits of the second operand. Both shifts use a combinational barrel shifter with one selector per output bit, so every count costs the same. The bit last pushed off the end of the word is reported on the overflow flag.

The computation is combinational. The block samples its inputs on the rising clock edge and holds the result and flags in output registers, so every answer appears one clock after its operands. A synchronous active-high reset clears the output registers. Three operation codes are reserved. They give a zero result and leave the flag strobe low, so the outside flag register keeps its contents.

Top module: `opalu_top`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `res_q` = 0 and `flag_n` = `flag_z` = `flag_o` = `flag_we` = 0, whatever the operands and code are.
- R2: The result and flags that follow from the inputs sampled at one rising edge appear on the outputs just after that edge. They stay there until the next edge.
- R3: Code 0000 gives result 0x0000. Code 0001 gives result 0xFFFF. Both ignore the operands.
- R4: Code 0010 gives ~A. Code 1000 gives B. Code 1001 gives A&B, code 1010 gives A|B and code 1011 gives A^B.
- R5: Code 1100 gives A+B and code 1101 gives A−B, both modulo 2^16. The overflow flag is set exactly when the two's-complement result overflows.
- R6: Code 0011 gives −A (two's complement). The overflow flag is set only for A = 0x8000.
- R7: Code 1110 (compare) gives result B−A. Its flags are derived from that difference, and the overflow flag marks a signed overflow of B−A.
- R8: Code 0100 shifts A left and code 0101 shifts A right by B[3:0] positions, with zeros filling the vacated bits. The overflow flag holds the last bit shifted out: bit 16−n of A for a left shift and bit n−1 of A for a right shift.
- R9: A shift with B[3:0] = 0 returns A unchanged and clears the overflow flag.
- R10: For every defined code, `flag_n` equals result bit 15 and `flag_z` is set exactly when the result is zero. The overflow flag is 0 for codes 0000, 0001, 0010 and 1000 to 1011.
- R11: Codes 0110, 0111 and 1111 give result 0 with all three flags and `flag_we` low.
- R12: `flag_we` is high for every one of the thirteen defined codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled and outputs updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| in_a | input | 16 | First operand (A) |
| in_b | input | 16 | Second operand (B); low four bits are the shift count |
| in_op | input | 4 | Operation code |
| res_q | output | 16 | Registered result |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_o | output | 1 | Registered overflow / shifted-out bit flag |
| flag_we | output | 1 | Registered strobe: flag register should take the new flags |

## Verification
Every output of this block is due exactly one rising edge after its operands and code are applied, because the only storage on the path is the output register. The bench changes inputs on the falling edge and compares result and flags on the next falling edge. By then the single capturing edge has passed and the following one has not yet arrived. One directed step also samples a quarter cycle before the capturing edge, to show the new result has not appeared early. Another applies reset while a nonzero operation is held, to show the clear happens on the same edge.

// File: rtl/opalu_pkg.sv
package opalu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_CLR   = 4'h0,
    OP_SET   = 4'h1,
    OP_NOT   = 4'h2,
    OP_NEG   = 4'h3,
    OP_SHL   = 4'h4,
    OP_SHR   = 4'h5,
    OP_RSV6  = 4'h6,
    OP_RSV7  = 4'h7,
    OP_PASSB = 4'h8,
    OP_AND   = 4'h9,
    OP_OR    = 4'hA,
    OP_XOR   = 4'hB,
    OP_ADD   = 4'hC,
    OP_SUB   = 4'hD,
    OP_CMP   = 4'hE,
    OP_RSVF  = 4'hF
  } op_e;

  typedef enum logic [1:0] {
    GRP_LOGIC,
    GRP_ARITH,
    GRP_SHIFT,
    GRP_NONE
  } grp_e;

  // Which functional unit supplies the result for a code.
  function automatic grp_e op_group(op_e op);
    case (op)
      OP_NEG, OP_ADD, OP_SUB, OP_CMP: return GRP_ARITH;
      OP_SHL, OP_SHR:                 return GRP_SHIFT;
      OP_RSV6, OP_RSV7, OP_RSVF:      return GRP_NONE;
      default:                        return GRP_LOGIC;
    endcase
  endfunction

endpackage

// File: rtl/opalu_shift.sv
// Combinational barrel shifter: every output bit owns a selector that
// picks among all shift amounts; a further selector picks the bit that
// left the word last.
module opalu_shift #(
  parameter int W    = 16,
  parameter int CW   = $clog2(W),
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0]  a,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  y,
  output logic          spill
);
  localparam int NSH = 1 << CW;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [NSH-1:0] pick;
    for (genvar s = 0; s < NSH; s++) begin : g_amt
      if (LEFT && (i >= s)) begin : g_l
        assign pick[s] = a[i-s];
      end else if (!LEFT && (i + s < W)) begin : g_r
        assign pick[s] = a[i+s];
      end else begin : g_z
        assign pick[s] = 1'b0;
      end
    end
    assign y[i] = pick[cnt];
  end

  logic [NSH-1:0] out_pick;
  for (genvar s = 0; s < NSH; s++) begin : g_spill
    if ((s == 0) || (s > W)) begin : g_none
      assign out_pick[s] = 1'b0;
    end else if (LEFT) begin : g_l
      assign out_pick[s] = a[W-s];
    end else begin : g_r
      assign out_pick[s] = a[s-1];
    end
  end
  assign spill = out_pick[cnt];

endmodule

// File: rtl/opalu_arith.sv
// One shared adder serves add, subtract, negate and reverse compare.
module opalu_arith
  import opalu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         ovf
);
  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic         cin;

  always_comb begin
    case (op)
      OP_SUB:  begin lhs = a;  rhs = ~b; end
      OP_NEG:  begin lhs = '0; rhs = ~a; end
      OP_CMP:  begin lhs = b;  rhs = ~a; end
      default: begin lhs = a;  rhs = b;  end
    endcase
  end

  assign cin = (op == OP_SUB) || (op == OP_NEG) || (op == OP_CMP);
  assign y   = lhs + rhs + {{(W-1){1'b0}}, cin};
  // Signed overflow: like-signed addends giving a differently signed sum.
  assign ovf = (lhs[W-1] == rhs[W-1]) && (y[W-1] != lhs[W-1]);

endmodule

// File: rtl/opalu_logic.sv
module opalu_logic
  import opalu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_SET:   y = '1;
      OP_NOT:   y = ~a;
      OP_PASSB: y = b;
      OP_AND:   y = a & b;
      OP_OR:    y = a | b;
      OP_XOR:   y = a ^ b;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/opalu_top.sv
module opalu_top
  import opalu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [OP_W-1:0]  in_op,
  output logic [WIDTH-1:0] res_q,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_o,
  output logic             flag_we
);
  localparam int CNT_W = $clog2(WIDTH);

  op_e  op;
  grp_e grp;
  assign op  = op_e'(in_op);
  assign grp = op_group(op);

  logic [WIDTH-1:0] lg_y, ar_y, shl_y, shr_y;
  logic             ar_ovf, shl_out, shr_out;

  opalu_logic #(.W(WIDTH)) u_logic (
    .op(op), .a(in_a), .b(in_b), .y(lg_y)
  );

  opalu_arith #(.W(WIDTH)) u_arith (
    .op(op), .a(in_a), .b(in_b), .y(ar_y), .ovf(ar_ovf)
  );

  opalu_shift #(.W(WIDTH), .CW(CNT_W), .LEFT(1'b1)) u_shl (
    .a(in_a), .cnt(in_b[CNT_W-1:0]), .y(shl_y), .spill(shl_out)
  );

  opalu_shift #(.W(WIDTH), .CW(CNT_W), .LEFT(1'b0)) u_shr (
    .a(in_a), .cnt(in_b[CNT_W-1:0]), .y(shr_y), .spill(shr_out)
  );

  logic [WIDTH-1:0] nxt_res;
  logic             nxt_o, nxt_we, nxt_n, nxt_z;

  always_comb begin
    nxt_res = '0;
    nxt_o   = 1'b0;
    nxt_we  = 1'b1;
    case (grp)
      GRP_ARITH: begin
        nxt_res = ar_y;
        nxt_o   = ar_ovf;
      end
      GRP_SHIFT: begin
        if (op == OP_SHL) begin
          nxt_res = shl_y;
          nxt_o   = shl_out;
        end else begin
          nxt_res = shr_y;
          nxt_o   = shr_out;
        end
      end
      GRP_NONE: nxt_we = 1'b0;
      default:  nxt_res = lg_y;
    endcase
  end

  assign nxt_n = nxt_we & nxt_res[WIDTH-1];
  assign nxt_z = nxt_we & ~(|nxt_res);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_o  <= 1'b0;
      flag_we <= 1'b0;
    end else begin
      res_q   <= nxt_res;
      flag_n  <= nxt_n;
      flag_z  <= nxt_z;
      flag_o  <= nxt_o;
      flag_we <= nxt_we;
    end
  end

endmodule

// File: rtl/opalu_chk.sv
module opalu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [3:0]   in_op,
  input logic [W-1:0] res_q,
  input logic         flag_n,
  input logic         flag_z,
  input logic         flag_o,
  input logic         flag_we
);
  localparam int CW = $clog2(W);

  logic rsv_code;
  assign rsv_code = (in_op == 4'h6) || (in_op == 4'h7) || (in_op == 4'hF);

  AST_PASS_B: assert property (@(posedge clk) disable iff (rst)
    (in_op == 4'h8) |=> (res_q == $past(in_b))); // R4

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
    (in_op == 4'hC) |=> (res_q == $past(in_a) + $past(in_b))); // R5

  AST_CMP_DIFF: assert property (@(posedge clk) disable iff (rst)
    (in_op == 4'hE) |=> (res_q == $past(in_b) - $past(in_a))); // R7

  AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (((in_op == 4'h4) || (in_op == 4'h5)) && (in_b[CW-1:0] == '0))
      |=> ((res_q == $past(in_a)) && !flag_o)); // R9

  AST_FLAG_NZ: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> ((flag_n == res_q[W-1]) && (flag_z == (res_q == '0)))); // R10

  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (rst)
    rsv_code |=> ((res_q == '0) && !flag_we && !flag_n && !flag_z && !flag_o)); // R11

  AST_STROBE_ON: assert property (@(posedge clk) disable iff (rst)
    !rsv_code |=> flag_we); // R12

endmodule

bind opalu_top opalu_chk #(.W(WIDTH)) chk_i (
  .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_op(in_op),
  .res_q(res_q), .flag_n(flag_n), .flag_z(flag_z), .flag_o(flag_o),
  .flag_we(flag_we)
);

// File: tb/opalu_top_tb_top.sv
module opalu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_a = 16'h0;
  logic [15:0] in_b = 16'h0;
  logic [3:0]  in_op = 4'h1;
  logic [15:0] res_q;
  logic        flag_n, flag_z, flag_o, flag_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  opalu_top #(.WIDTH(16)) dut_i (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_op(in_op),
    .res_q(res_q), .flag_n(flag_n), .flag_z(flag_z), .flag_o(flag_o),
    .flag_we(flag_we)
  );

  // {op, a, b, expected result, n z o we}
  localparam int NV = 29;
  localparam logic [55:0] VEC [NV] = '{
    {4'h0, 16'h1234, 16'h5678, 16'h0000, 4'b0101},
    {4'h1, 16'h1234, 16'h5678, 16'hFFFF, 4'b1001},
    {4'h2, 16'h00FF, 16'h0000, 16'hFF00, 4'b1001},
    {4'h3, 16'h0001, 16'h0000, 16'hFFFF, 4'b1001},
    {4'h3, 16'h8000, 16'h0000, 16'h8000, 4'b1011},
    {4'h3, 16'h0000, 16'h0000, 16'h0000, 4'b0101},
    {4'h4, 16'h0069, 16'h0001, 16'h00D2, 4'b0001},
    {4'h4, 16'h8001, 16'h0001, 16'h0002, 4'b0011},
    {4'h4, 16'h0003, 16'h000F, 16'h8000, 4'b1011},
    {4'h5, 16'h0069, 16'h0001, 16'h0034, 4'b0011},
    {4'h5, 16'h8000, 16'h000F, 16'h0001, 4'b0001},
    {4'h5, 16'h00F0, 16'h0014, 16'h000F, 4'b0001},
    {4'h4, 16'hABCD, 16'h0010, 16'hABCD, 4'b1001},
    {4'h5, 16'hABCD, 16'h0000, 16'hABCD, 4'b1001},
    {4'h8, 16'h1111, 16'hBEEF, 16'hBEEF, 4'b1001},
    {4'h9, 16'hF0F0, 16'hFF00, 16'hF000, 4'b1001},
    {4'hA, 16'hF0F0, 16'h0F0F, 16'hFFFF, 4'b1001},
    {4'hB, 16'hAAAA, 16'hAAAA, 16'h0000, 4'b0101},
    {4'hC, 16'h7FFF, 16'h0001, 16'h8000, 4'b1011},
    {4'hC, 16'hFFFF, 16'h0001, 16'h0000, 4'b0101},
    {4'hC, 16'h8000, 16'h8000, 16'h0000, 4'b0111},
    {4'hD, 16'h0005, 16'h0007, 16'hFFFE, 4'b1001},
    {4'hD, 16'h8000, 16'h0001, 16'h7FFF, 4'b0011},
    {4'hE, 16'h00C8, 16'h0005, 16'hFF3D, 4'b1001},
    {4'hE, 16'h0005, 16'h0005, 16'h0000, 4'b0101},
    {4'hE, 16'h0001, 16'h8000, 16'h7FFF, 4'b0011},
    {4'h6, 16'h1234, 16'h0001, 16'h0000, 4'b0000},
    {4'h7, 16'hFFFF, 16'hFFFF, 16'h0000, 4'b0000},
    {4'hF, 16'h8000, 16'h0001, 16'h0000, 4'b0000}
  };

  function automatic string req_of(logic [3:0] op, logic [15:0] b);
    case (op)
      4'h0, 4'h1: return "R3";
      4'h2, 4'h8, 4'h9, 4'hA, 4'hB: return "R4";
      4'hC, 4'hD: return "R5";
      4'h3: return "R6";
      4'hE: return "R7";
      4'h4, 4'h5: return (b[3:0] == 4'h0) ? "R9" : "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] flags_now();
    return {flag_n, flag_z, flag_o, flag_we};
  endfunction

  initial begin
    // R1: reset dominates a set-all-ones code on the inputs
    repeat (2) @(negedge clk);
    check(res_q == 16'h0, "R1", "reset result", 32'(res_q), 32'h0);
    check(flags_now() == 4'b0000, "R1", "reset flags", 32'(flags_now()), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      v = VEC[i];
      in_op = v[55:52];
      in_a  = v[51:36];
      in_b  = v[35:20];
      @(negedge clk);
      check(res_q == v[19:4], req_of(v[55:52], v[35:20]),
            $sformatf("result vec %0d", i), 32'(res_q), 32'(v[19:4]));
      check(flags_now() == v[3:0],
            (v[0] ? "R10 R12" : "R11"),
            $sformatf("flags nzo_we vec %0d", i), 32'(flags_now()), 32'(v[3:0]));
    end

    // R2: new result not visible before the capturing edge, visible after it
    in_op = 4'h1; in_a = 16'h0; in_b = 16'h0;
    #5;
    check(res_q == 16'h0, "R2", "early sample", 32'(res_q), 32'h0);
    @(negedge clk);
    check(res_q == 16'hFFFF, "R2", "one edge later", 32'(res_q), 32'hFFFF);

    // R1: reset mid-run while a nonzero code is held
    rst = 1'b1;
    @(negedge clk);
    check(res_q == 16'h0, "R1", "mid-run reset result", 32'(res_q), 32'h0);
    check(flag_we == 1'b0, "R1", "mid-run reset strobe", 32'(flag_we), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(res_q == 16'hFFFF, "R2", "after reset release", 32'(res_q), 32'hFFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule